// File: doc/BRIEF.md
# Modem Input Change Detector

This block watches an asynchronous, active-low clear-to-send input. The pin passes through a two-flop synchronizer. A duration filter follows it and accepts a new level only after the level has stayed put for a set number of serial-clock ticks. The block keeps the accepted level as a current-state bit. Any accepted transition, high-to-low or low-to-high, latches a sticky change flag.

A CPU reads an 8-bit status byte, and that read clears the flag. An interrupt request stays high while the flag is set and the enable input is 1. After reset the block waits two serial-clock ticks and then takes one initial sample without filtering. If the input is already asserted at that sample, the block counts it as a change.

Top module: `modem_chg_det`

## Requirements
- R1: The status byte carries the change flag at bit 4 and the current-state bit at bit 0. Bits 7..5 and 3..1 always read 0.
- R2: Once a level is accepted, the current-state bit reads 0 for a low (asserted) input and 1 for a high (negated) input.
- R3: A new input level is accepted only after it has differed from the current state for FILT_TICKS consecutive tick strobes. With the default, FILT_TICKS is 4. A level that returns earlier is ignored, and its count restarts from zero.
- R4: Every accepted transition sets the change flag, whether it goes high-to-low or low-to-high.
- R5: A one-cycle read strobe clears the change flag on the next clock edge, unless a new change arrives in that same cycle.
- R6: Reset forces the status byte to 0x01 and the interrupt output to 0. The current-state bit stays 1 until the second tick strobe after reset is released.
- R7: On the second tick after reset, the synchronized input is taken directly as the current state, with no filtering. If it is low, the change flag is set and the status byte reads 0x10.
- R8: When an accepted change and a clearing read fall in the same cycle, the flag ends up 1.
- R9: The interrupt output is a registered copy of (flag AND enable). It falls one cycle after the flag clears, and it stays 0 while the enable input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Serial-clock tick, one system-clock cycle wide |
| cts_n_i | input | 1 | Raw clear-to-send pin, active low, asynchronous |
| rd_i | input | 1 | Status read strobe, one cycle wide |
| irq_en_i | input | 1 | Interrupt enable |
| status_o | output | 8 | Status byte: bit 4 change flag, bit 0 current state |
| irq_o | output | 1 | Interrupt request, registered level |

## Verification
The assertions assume that tick_i and rd_i are single-cycle strobes. They also assume that the input is held steady while the filter is counting, so that every accepted level is preceded by a tick. The bench drives the strobes from tasks that raise them for exactly one cycle. After every pin change it waits three clocks before the first counted tick, so that the synchronizer has settled and the tick count decides the result. The read-versus-change collision is built by placing the read in the cycle right after the accepting tick.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int unsigned STAT_W       = 8;
    localparam int unsigned STAT_FLAG_IX = 4;
    localparam int unsigned STAT_CUR_IX  = 0;

    typedef struct packed {
        logic flag;
        logic irq;
    } evt_state_t;

    function automatic logic [STAT_W-1:0] pack_status(input logic flag, input logic cur);
        logic [STAT_W-1:0] s;
        s = '0;
        s[STAT_FLAG_IX] = flag;
        s[STAT_CUR_IX]  = cur;
        return s;
    endfunction
endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mcd_filter.sv
module mcd_filter #(
    parameter int unsigned FILT_TICKS = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sync_i,
    output logic lvl_o,
    output logic chg_o
);
    localparam int unsigned CNT_W = (FILT_TICKS > 2) ? $clog2(FILT_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_TICKS - 1);

    typedef struct packed {
        logic             armed;
        logic             boot;
        logic             lvl;
        logic             chg;
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (!st_q.armed) begin
            if (tick_i) begin
                if (st_q.boot) begin
                    st_d.armed = 1'b1;
                    st_d.lvl   = sync_i;
                    st_d.chg   = (sync_i != st_q.lvl);
                end else begin
                    st_d.boot = 1'b1;
                end
            end
        end else if (sync_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.lvl = sync_i;
                st_d.cnt = '0;
                st_d.chg = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{armed: 1'b0, boot: 1'b0, lvl: 1'b1, chg: 1'b0, cnt: '0};
        else         st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;
    assign chg_o = st_q.chg;

    // R3: the accepted level only moves on a tick
    a_r3_level_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.lvl) |-> $past(tick_i));
    // R6: negated level held until the boot sample is taken
    a_r6_negated_before_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.armed |-> st_q.lvl);
    // R4: change indication is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg_o |=> !chg_o);
endmodule

// File: rtl/mcd_event.sv
module mcd_event
    import mcd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic chg_i,
    input  logic rd_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    evt_state_t ev_d, ev_q;

    always_comb begin
        ev_d      = ev_q;
        ev_d.flag = chg_i | (ev_q.flag & ~rd_i);
        ev_d.irq  = ev_q.flag & irq_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ev_q <= '0;
        else         ev_q <= ev_d;
    end

    assign flag_o = ev_q.flag;
    assign irq_o  = ev_q.irq;

    // R5: a read with no new change clears the flag
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !chg_i) |=> !flag_o);
    // R8: a change always leaves the flag set, read or not
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chg_i |=> flag_o);
    // R9: no request one cycle after the flag is clear
    a_r9_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_o |=> !irq_o);
    // R9: disabled means no request next cycle
    a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |=> !irq_o);
endmodule

// File: rtl/modem_chg_det.sv
module modem_chg_det
    import mcd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_TICKS  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cts_n_i,
    input  logic              rd_i,
    input  logic              irq_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic sync_lvl, acc_lvl, acc_chg, flag;

    mcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (cts_n_i),
        .q_o   (sync_lvl)
    );

    mcd_filter #(.FILT_TICKS(FILT_TICKS)) u_filter (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(tick_i),
        .sync_i(sync_lvl),
        .lvl_o (acc_lvl),
        .chg_o (acc_chg)
    );

    mcd_event u_event (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .chg_i   (acc_chg),
        .rd_i    (rd_i),
        .irq_en_i(irq_en_i),
        .flag_o  (flag),
        .irq_o   (irq_o)
    );

    assign status_o = pack_status(flag, acc_lvl);

    // R1: reserved status bits stay zero
    a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & 8'hEE) == 8'h00);
endmodule

// File: tb/modem_chg_det_tb.sv
module modem_chg_det_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cts_n = 1'b1, rd = 1'b0, en = 1'b0;
    logic [7:0] status;
    logic irq;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    modem_chg_det dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cts_n_i(cts_n),
        .rd_i(rd), .irq_en_i(en), .status_o(status), .irq_o(irq)
    );

    // {cts_n, ticks, read_after, enable, expected status, expected irq}
    typedef struct packed {
        logic       cts;
        logic [2:0] nt;
        logic       rdx;
        logic       ena;
        logic [7:0] st;
        logic       iq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd4, 1'b1, 1'b1, 8'h10, 1'b1},  // R4 R2 falling accepted
        '{1'b0, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0},  // R5 cleared by read
        '{1'b1, 3'd3, 1'b0, 1'b1, 8'h00, 1'b0},  // R3 short pulse ignored
        '{1'b0, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0},  // R3 pulse gone
        '{1'b1, 3'd4, 1'b1, 1'b0, 8'h11, 1'b0},  // R4 rising, R9 masked
        '{1'b1, 3'd0, 1'b0, 1'b1, 8'h01, 1'b0},  // R5 R2
        '{1'b0, 3'd4, 1'b0, 1'b1, 8'h10, 1'b1},  // R9 raised
        '{1'b0, 3'd0, 1'b1, 1'b0, 8'h10, 1'b0},  // R9 enable dropped
        '{1'b0, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0}   // R5 R1
    };

    task automatic chk(input string req, input logic [7:0] st_exp, input logic iq_exp);
        n_chk++;
        if (status !== st_exp || irq !== iq_exp) begin
            n_fail++;
            $display("FAIL %s status=%h irq=%b expected status=%h irq=%b",
                     req, status, irq, st_exp, iq_exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic do_reset(input logic pin);
        cts_n = pin; rst_n = 1'b0; tick = 1'b0; rd = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        en = 1'b1;
        // R6 R7: boot with the input asserted
        do_reset(1'b0);
        chk("R6 reset state", 8'h01, 1'b0);
        pulse_tick(); cyc(2);
        chk("R6 held after first tick", 8'h01, 1'b0);
        pulse_tick(); cyc(2);
        chk("R7 boot sample low flags change", 8'h10, 1'b1);

        // R6 R7: boot with the input negated
        do_reset(1'b1);
        chk("R6 reset state", 8'h01, 1'b0);
        pulse_tick(); pulse_tick(); cyc(3);
        chk("R7 boot sample high no change", 8'h01, 1'b0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            cts_n = VECS[v].cts; en = VECS[v].ena;
            cyc(3);
            for (int t = 0; t < int'(VECS[v].nt); t++) pulse_tick();
            cyc(3);
            chk($sformatf("vector %0d R1 R2 R3 R4 R5 R9", v), VECS[v].st, VECS[v].iq);
            if (VECS[v].rdx) pulse_rd();
        end

        // R9: request falls exactly one cycle after flag clears
        en = 1'b1; cts_n = 1'b1; cyc(3);
        for (int t = 0; t < 4; t++) pulse_tick();
        cyc(3);
        chk("R9 setup", 8'h11, 1'b1);
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk("R9 flag clear irq still high", 8'h01, 1'b1);
        @(negedge clk);
        chk("R9 irq dropped next cycle", 8'h01, 1'b0);

        // R8: accepted change in same cycle as read
        cts_n = 1'b0; cyc(3);
        for (int t = 0; t < 3; t++) pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        cyc(1);
        chk("R8 set wins over read", 8'h10, 1'b1);

        // R3: count restarts after an interrupted pulse
        pulse_rd(); cyc(2);
        cts_n = 1'b1; cyc(3);
        for (int t = 0; t < 3; t++) pulse_tick();
        cts_n = 1'b0; cyc(3);
        cts_n = 1'b1; cyc(3);
        pulse_tick(); cyc(3);
        chk("R3 count restarted", 8'h00, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int w = 0; w < 20000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule